// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block turns a pixel clock into the sync and framing signals a raster display needs. It drives a horizontal sync, a vertical sync, a data-enable, the column and row of the current active pixel, and a one-clock frame-done strobe. It also gates an incoming 6-bit-per-colour RGB stream, so that pixel data reaches the output only inside the visible window.

All timing comes from five 32-bit words written through a plain write port. A write lands in a staging copy. The whole set moves into the working copy on the last clock of a frame, so a frame never mixes two configurations. Vertical period and vertical pulse width can each be counted in whole lines or in pixel clocks. Sync polarity is selectable per axis. An enable bit parks both syncs at their idle level.

Top module: `disp_timing_gen`

## Requirements
- R1: While reset is low, and on the first clock after it, hsync and vsync sit at the idle level of the reset configuration, and de, frame_done, pos_x, pos_y and the RGB outputs are all zero. The counters restart at column 0, row 0.
- R2: Word 0 sets the line length in pixel clocks in bits [15:0] and the hsync width in bits [31:24]. Hsync is active for the first width clocks of every line. Every output is registered and shows the counter state of the previous clock.
- R3: When mode bit 2 is set, the frame is word 1 bits [15:0] whole lines long. When mode bit 3 is set, vsync is active during the first N lines, with N taken from mode bits [31:16]. Its edges therefore fall on the same clock as a hsync assertion edge.
- R4: When mode bit 2 is clear, the frame length in pixel clocks is word 1 bits [15:0]. When mode bit 3 is clear, vsync is active for the first N pixel clocks of the frame. The two bits act independently.
- R5: Mode bit 0 sets the hsync polarity and mode bit 1 sets the vsync polarity. A value of 0 gives an active-low pulse and 1 an active-high pulse. The idle level is the inverse of the active level.
- R6: de is high exactly when the column lies in [first_col, first_col+cols) and the row lies in [first_row, first_row+rows). Word 3 gives rows in [31:16] and cols in [15:0]. Word 4 gives first_row in [31:16] and first_col in [15:0].
- R7: While de is high, pos_x is column minus first_col and pos_y is row minus first_row. While de is low, both are zero.
- R8: While de is high, out_r, out_g and out_b equal the pixel inputs from the previous clock. Otherwise they are zero.
- R9: frame_done is high for exactly one clock, one clock after the last clock of each frame. On the following clock the counters are back at column 0, row 0.
- R10: A write to address 0 to 4 changes nothing in the current frame. All five words take effect together from the first clock of the next frame. Writes to addresses 5 to 7 are ignored.
- R11: While mode bit 4 (output enable) is clear, hsync and vsync stay at their idle levels. de, the coordinates, RGB and frame_done keep running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the control words |
| cfg_addr | input | AW (3) | Control word index |
| cfg_wdata | input | 32 | Control word value |
| pix_r | input | CDW (6) | Red pixel input |
| pix_g | input | CDW (6) | Green pixel input |
| pix_b | input | CDW (6) | Blue pixel input |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Active-region data enable |
| pos_x | output | 16 | Active column index |
| pos_y | output | 16 | Active row index |
| out_r | output | CDW (6) | Gated red output |
| out_g | output | CDW (6) | Gated green output |
| out_b | output | CDW (6) | Gated blue output |
| frame_done | output | 1 | One-clock end-of-frame strobe |

## Verification
The bench reprograms the block in the middle of a frame. A design that applied words at once would show a shorter or shifted line inside that frame, and the every-clock comparison would flag it on the next clock. It exercises both counting units and a mixed case: period in lines with the pulse in clocks. An implementation that tied the two unit bits together would either misplace the end of the frame or stretch vsync across several lines. Polarity is flipped in both directions, and output enable is cleared while the active region keeps running. This catches a design that also gates de, or that parks the syncs at the wrong level. The window edges are compared on every clock, so an off-by-one in the active window start or length shows up as a de or coordinate mismatch.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  localparam int WORD_W = 32;
  localparam int CNT_W  = 16;
  localparam int FC_W   = 32;
  localparam int NREG   = 5;

  localparam int IDX_HTIME  = 0;
  localparam int IDX_VTIME  = 1;
  localparam int IDX_MODE   = 2;
  localparam int IDX_ACTIVE = 3;
  localparam int IDX_ORIGIN = 4;

  typedef struct packed {
    logic [7:0]       hsw;
    logic [CNT_W-1:0] hper;
    logic [CNT_W-1:0] vper;
    logic [CNT_W-1:0] vsw;
    logic             hpol;
    logic             vpol;
    logic             vper_lines;
    logic             vsw_lines;
    logic             oe;
    logic [CNT_W-1:0] rows;
    logic [CNT_W-1:0] cols;
    logic [CNT_W-1:0] first_row;
    logic [CNT_W-1:0] first_col;
  } cfg_t;

  // Unpack the five control words into named fields.
  function automatic cfg_t decode_cfg(input logic [WORD_W-1:0] w_h,
                                      input logic [WORD_W-1:0] w_v,
                                      input logic [WORD_W-1:0] w_m,
                                      input logic [WORD_W-1:0] w_a,
                                      input logic [WORD_W-1:0] w_o);
    cfg_t c;
    c.hsw        = w_h[31:24];
    c.hper       = w_h[15:0];
    c.vper       = w_v[15:0];
    c.vsw        = w_m[31:16];
    c.hpol       = w_m[0];
    c.vpol       = w_m[1];
    c.vper_lines = w_m[2];
    c.vsw_lines  = w_m[3];
    c.oe         = w_m[4];
    c.rows       = w_a[31:16];
    c.cols       = w_a[15:0];
    c.first_row  = w_o[31:16];
    c.first_col  = w_o[15:0];
    return c;
  endfunction

  // True on the final count of a period; periods of 0 or 1 end every clock.
  function automatic logic is_last(input logic [FC_W-1:0] cnt,
                                   input logic [CNT_W-1:0] per);
    logic [FC_W-1:0] lim;
    lim = FC_W'(per) - FC_W'(1);
    return (per <= CNT_W'(1)) || (cnt >= lim);
  endfunction

  // Half-open window test: start <= pos < start + len.
  function automatic logic in_window(input logic [CNT_W-1:0] pos,
                                     input logic [CNT_W-1:0] start,
                                     input logic [CNT_W-1:0] len);
    logic [CNT_W:0] p;
    logic [CNT_W:0] s;
    logic [CNT_W:0] e;
    p = {1'b0, pos};
    s = {1'b0, start};
    e = s + {1'b0, len};
    return (p >= s) && (p < e);
  endfunction

  // Pin level for a sync: active level only while enabled and in the pulse.
  function automatic logic sync_level(input logic active,
                                      input logic pol,
                                      input logic en);
    return (en && active) ? pol : ~pol;
  endfunction

endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
  import dtg_pkg::*;
#(
  parameter int              AW         = 3,
  parameter logic [31:0]     RST_HTIME  = 32'h6000_0320,
  parameter logic [31:0]     RST_VTIME  = 32'h0000_020C,
  parameter logic [31:0]     RST_MODE   = 32'h0002_001C,
  parameter logic [31:0]     RST_ACTIVE = 32'h01E0_0280,
  parameter logic [31:0]     RST_ORIGIN = 32'h0021_0090
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              frame_last,
  output cfg_t              cfg,
  output logic [WORD_W-1:0] live_htime
);

  localparam logic [WORD_W-1:0] RSTV [NREG] =
    '{RST_HTIME, RST_VTIME, RST_MODE, RST_ACTIVE, RST_ORIGIN};

  logic [WORD_W-1:0] stg  [NREG];
  logic [WORD_W-1:0] live [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_word
    logic hit;
    assign hit = wr && (addr == AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg[i]  <= RSTV[i];
        live[i] <= RSTV[i];
      end else begin
        if (frame_last) live[i] <= stg[i];
        if (hit)        stg[i]  <= wdata;
      end
    end
  end

  assign cfg = decode_cfg(live[IDX_HTIME], live[IDX_VTIME], live[IDX_MODE],
                          live[IDX_ACTIVE], live[IDX_ORIGIN]);
  assign live_htime = live[IDX_HTIME];

endmodule

// File: rtl/dtg_counters.sv
module dtg_counters
  import dtg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_t             cfg,
  output logic [CNT_W-1:0] hc,
  output logic [CNT_W-1:0] vc,
  output logic [FC_W-1:0]  fc,
  output logic             line_last,
  output logic             frame_last
);

  logic row_last;
  logic clk_last;

  assign line_last  = is_last(FC_W'(hc), cfg.hper);
  assign row_last   = is_last(FC_W'(vc), cfg.vper);
  assign clk_last   = is_last(fc, cfg.vper);
  assign frame_last = cfg.vper_lines ? (line_last && row_last) : clk_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc <= '0;
      vc <= '0;
      fc <= '0;
    end else if (frame_last) begin
      hc <= '0;
      vc <= '0;
      fc <= '0;
    end else if (line_last) begin
      hc <= '0;
      vc <= vc + CNT_W'(1);
      fc <= fc + FC_W'(1);
    end else begin
      hc <= hc + CNT_W'(1);
      fc <= fc + FC_W'(1);
    end
  end

endmodule

// File: rtl/dtg_shaper.sv
module dtg_shaper
  import dtg_pkg::*;
#(
  parameter int          CDW      = 6,
  parameter logic [31:0] RST_MODE = 32'h0002_001C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_t             cfg,
  input  logic [CNT_W-1:0] hc,
  input  logic [CNT_W-1:0] vc,
  input  logic [FC_W-1:0]  fc,
  input  logic             frame_last,
  input  logic [CDW-1:0]   in_r,
  input  logic [CDW-1:0]   in_g,
  input  logic [CDW-1:0]   in_b,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [CNT_W-1:0] pos_x,
  output logic [CNT_W-1:0] pos_y,
  output logic [CDW-1:0]   out_r,
  output logic [CDW-1:0]   out_g,
  output logic [CDW-1:0]   out_b,
  output logic             frame_done
);

  logic hs_act;
  logic vs_act;
  logic h_in;
  logic v_in;
  logic de_n;

  assign hs_act = FC_W'(hc) < FC_W'(cfg.hsw);
  assign vs_act = cfg.vsw_lines ? (vc < cfg.vsw) : (fc < FC_W'(cfg.vsw));
  assign h_in   = in_window(hc, cfg.first_col, cfg.cols);
  assign v_in   = in_window(vc, cfg.first_row, cfg.rows);
  assign de_n   = h_in && v_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync      <= ~RST_MODE[0];
      vsync      <= ~RST_MODE[1];
      de         <= 1'b0;
      pos_x      <= '0;
      pos_y      <= '0;
      out_r      <= '0;
      out_g      <= '0;
      out_b      <= '0;
      frame_done <= 1'b0;
    end else begin
      hsync      <= sync_level(hs_act, cfg.hpol, cfg.oe);
      vsync      <= sync_level(vs_act, cfg.vpol, cfg.oe);
      de         <= de_n;
      pos_x      <= de_n ? (hc - cfg.first_col) : '0;
      pos_y      <= de_n ? (vc - cfg.first_row) : '0;
      out_r      <= de_n ? in_r : '0;
      out_g      <= de_n ? in_g : '0;
      out_b      <= de_n ? in_b : '0;
      frame_done <= frame_last;
    end
  end

endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter int          AW         = 3,
  parameter int          CDW        = 6,
  parameter logic [31:0] RST_HTIME  = 32'h6000_0320,
  parameter logic [31:0] RST_VTIME  = 32'h0000_020C,
  parameter logic [31:0] RST_MODE   = 32'h0002_001C,
  parameter logic [31:0] RST_ACTIVE = 32'h01E0_0280,
  parameter logic [31:0] RST_ORIGIN = 32'h0021_0090
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [31:0]    cfg_wdata,
  input  logic [CDW-1:0] pix_r,
  input  logic [CDW-1:0] pix_g,
  input  logic [CDW-1:0] pix_b,
  output logic           hsync,
  output logic           vsync,
  output logic           de,
  output logic [15:0]    pos_x,
  output logic [15:0]    pos_y,
  output logic [CDW-1:0] out_r,
  output logic [CDW-1:0] out_g,
  output logic [CDW-1:0] out_b,
  output logic           frame_done
);

  cfg_t              cfg;
  logic [31:0]       live_htime;
  logic [CNT_W-1:0]  hc;
  logic [CNT_W-1:0]  vc;
  logic [FC_W-1:0]   fc;
  logic              line_last;
  logic              frame_last;

  dtg_regs #(
    .AW(AW), .RST_HTIME(RST_HTIME), .RST_VTIME(RST_VTIME), .RST_MODE(RST_MODE),
    .RST_ACTIVE(RST_ACTIVE), .RST_ORIGIN(RST_ORIGIN)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .frame_last(frame_last), .cfg(cfg), .live_htime(live_htime)
  );

  dtg_counters u_cnt (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .hc(hc), .vc(vc), .fc(fc),
    .line_last(line_last), .frame_last(frame_last)
  );

  dtg_shaper #(.CDW(CDW), .RST_MODE(RST_MODE)) u_shape (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .hc(hc), .vc(vc), .fc(fc),
    .frame_last(frame_last), .in_r(pix_r), .in_g(pix_g), .in_b(pix_b),
    .hsync(hsync), .vsync(vsync), .de(de), .pos_x(pos_x), .pos_y(pos_y),
    .out_r(out_r), .out_g(out_g), .out_b(out_b), .frame_done(frame_done)
  );

endmodule

// File: rtl/dtg_checker.sv
module dtg_checker #(
  parameter int CDW = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic [15:0]    hc,
  input logic [15:0]    vc,
  input logic           line_last,
  input logic           frame_last,
  input logic           cfg_oe,
  input logic           cfg_hpol,
  input logic [31:0]    live_htime,
  input logic           hsync,
  input logic           de,
  input logic [15:0]    pos_x,
  input logic [15:0]    pos_y,
  input logic [CDW-1:0] out_r,
  input logic [CDW-1:0] out_g,
  input logic [CDW-1:0] out_b,
  input logic           frame_done
);

  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    line_last |=> (hc == 16'd0)); // R2

  AST_FRAME_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_last |=> (hc == 16'd0 && vc == 16'd0)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R9

  AST_COORD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (pos_x == 16'd0 && pos_y == 16'd0)); // R7

  AST_RGB_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (out_r == '0 && out_g == '0 && out_b == '0)); // R8

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_last |=> $stable(live_htime)); // R10

  AST_OE_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_oe |=> (hsync == !$past(cfg_hpol))); // R11

endmodule

bind disp_timing_gen dtg_checker #(.CDW(CDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hc(hc), .vc(vc), .line_last(line_last),
  .frame_last(frame_last), .cfg_oe(cfg.oe), .cfg_hpol(cfg.hpol),
  .live_htime(live_htime), .hsync(hsync), .de(de), .pos_x(pos_x),
  .pos_y(pos_y), .out_r(out_r), .out_g(out_g), .out_b(out_b),
  .frame_done(frame_done)
);

// File: tb/tb_disp_timing_gen.sv
`timescale 1ns/1ps
module tb_disp_timing_gen;

  localparam logic [31:0] T_HTIME  = 32'h0300_0014; // hsw 3, line 20
  localparam logic [31:0] T_VTIME  = 32'h0000_000C; // 12 lines
  localparam logic [31:0] T_MODE   = 32'h0002_001C; // vsw 2 lines, oe, low pol
  localparam logic [31:0] T_ACTIVE = 32'h0006_000A; // 6 rows, 10 cols
  localparam logic [31:0] T_ORIGIN = 32'h0003_0005; // row 3, col 5

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [5:0] pix_r = '0, pix_g = '0, pix_b = '0;
  logic hsync, vsync, de, frame_done;
  logic [15:0] pos_x, pos_y;
  logic [5:0] out_r, out_g, out_b;

  always #10 clk = ~clk;

  disp_timing_gen #(
    .RST_HTIME(T_HTIME), .RST_VTIME(T_VTIME), .RST_MODE(T_MODE),
    .RST_ACTIVE(T_ACTIVE), .RST_ORIGIN(T_ORIGIN)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .hsync(hsync), .vsync(vsync), .de(de), .pos_x(pos_x), .pos_y(pos_y),
    .out_r(out_r), .out_g(out_g), .out_b(out_b), .frame_done(frame_done)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string phase = "R1 reset";
  bit started = 0;
  bit done = 0;

  // Behavioural reference model
  logic [31:0] m_stg [5];
  logic [31:0] m_live[5];
  int mh, mv, mf;
  bit e_hs, e_vs, e_de, e_fd;
  int e_x, e_y;
  logic [17:0] e_rgb;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stg  = '{T_HTIME, T_VTIME, T_MODE, T_ACTIVE, T_ORIGIN};
      m_live = '{T_HTIME, T_VTIME, T_MODE, T_ACTIVE, T_ORIGIN};
      mh = 0; mv = 0; mf = 0;
      e_hs = !T_MODE[0]; e_vs = !T_MODE[1];
      e_de = 0; e_fd = 0; e_x = 0; e_y = 0; e_rgb = '0;
      started = 1;
    end else begin
      int hsw, hper, vper, vsw, rows, cols, frow, fcol;
      bit hpol, vpol, vpl, vwl, oe, hs, vs, dd, lastl, lastf;
      hsw  = m_live[0] >> 24;
      hper = m_live[0] & 32'hFFFF;
      vper = m_live[1] & 32'hFFFF;
      vsw  = m_live[2] >> 16;
      hpol = m_live[2][0]; vpol = m_live[2][1];
      vpl  = m_live[2][2]; vwl  = m_live[2][3]; oe = m_live[2][4];
      rows = m_live[3] >> 16; cols = m_live[3] & 32'hFFFF;
      frow = m_live[4] >> 16; fcol = m_live[4] & 32'hFFFF;
      hs = (mh < hsw);
      vs = vwl ? (mv < vsw) : (mf < vsw);
      dd = (mh >= fcol) && (mh < fcol + cols) && (mv >= frow) && (mv < frow + rows);
      e_hs = (oe && hs) ? hpol : !hpol;
      e_vs = (oe && vs) ? vpol : !vpol;
      e_de = dd;
      e_x = dd ? mh - fcol : 0;
      e_y = dd ? mv - frow : 0;
      e_rgb = dd ? {pix_r, pix_g, pix_b} : 18'd0;
      lastl = (hper <= 1) || (mh >= hper - 1);
      lastf = vpl ? (lastl && ((vper <= 1) || (mv >= vper - 1)))
                  : ((vper <= 1) || (mf >= vper - 1));
      e_fd = lastf;
      if (lastf) begin
        mh = 0; mv = 0; mf = 0;
        for (int i = 0; i < 5; i++) m_live[i] = m_stg[i];
      end else if (lastl) begin
        mh = 0; mv++; mf++;
      end else begin
        mh++; mf++;
      end
      if (cfg_wr && cfg_addr < 3'd5) m_stg[cfg_addr] = cfg_wdata;
    end
  end

  task automatic chk(input bit ok, input string sig, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL [%s] %s actual=%0d expected=%0d", phase, sig, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk(hsync == e_hs, "R2 hsync", hsync, e_hs);
      chk(vsync == e_vs, "R3 vsync", vsync, e_vs);
      chk(de == e_de, "R6 de", de, e_de);
      chk(pos_x == 16'(e_x), "R7 pos_x", pos_x, e_x);
      chk(pos_y == 16'(e_y), "R7 pos_y", pos_y, e_y);
      chk({out_r, out_g, out_b} == e_rgb, "R8 rgb", {out_r, out_g, out_b}, e_rgb);
      chk(frame_done == e_fd, "R9 frame_done", frame_done, e_fd);
    end
  end

  // Pixel stimulus
  initial begin
    logic [17:0] lf;
    lf = 18'h2A5C3;
    forever begin
      @(negedge clk);
      lf = {lf[16:0], lf[17] ^ lf[10]};
      {pix_r, pix_g, pix_b} = lf;
    end
  end

  task automatic wr_word(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL [%s] watchdog expired actual=0 expected=1", phase);
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state compared on each clock while reset is held
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R3: line-counted frame and vsync, lines aligned to hsync assertion
    phase = "R3 lines";
    repeat (300) @(negedge clk);
    // R10: words written mid-frame must not alter the running frame
    phase = "R10 shadow";
    wr_word(3'd0, 32'h0400_0010);
    wr_word(3'd1, 32'h0000_00C8);
    wr_word(3'd2, 32'h0018_0013);
    wr_word(3'd3, 32'h0008_0008);
    wr_word(3'd4, 32'h0002_0006);
    repeat (200) @(negedge clk);
    // R4: period and pulse in pixel clocks, active-high syncs (R5)
    phase = "R4 clocks";
    repeat (500) @(negedge clk);
    // R5: back to active-low; mixed units (period lines, pulse clocks)
    phase = "R5 polarity";
    wr_word(3'd1, 32'h0000_000A);
    wr_word(3'd2, 32'h0005_0014);
    repeat (600) @(negedge clk);
    // R11: output enable cleared with active-high polarity; R10 writes to 5..7 ignored
    phase = "R11 disabled";
    wr_word(3'd2, 32'h0002_000F);
    wr_word(3'd7, 32'h0000_0000);
    wr_word(3'd5, 32'hFFFF_FFFF);
    repeat (500) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule